// File: doc/BRIEF.md
# Dual-Half Hamming Parity Generator

This block sits beside the byte data path of a NAND flash controller and computes a single-error-correcting Hamming code over a 512-byte chunk. The chunk is treated as two independent 256-byte halves, and each half gets its own set of line and column parity. Software selects what the block does by writing a mode command. One command clears the accumulators, one starts accumulation over the bytes that follow, and one turns the data register into a readout port for the six code bytes.

Each half yields 16 line-parity bits and 6 column-parity bits. Every parity bit is kept inverted, so an erased chunk of all 0xFF bytes produces an all-ones code. Readout returns the six bytes as three 16-bit words, with the two halves interleaved across them. A read pointer steps through the three words and wraps back to the first. In the intended flow, a dummy data read follows the clear command. That byte arrives before accumulation is enabled and is not counted.

Top module: `dual_hamming_ecc`

## Requirements
- R1: After `rst`, and whenever the block is not in result mode, `rd_word` reads 0x0000. A synchronous reset clears both parity sets and the byte count.
- R2: Command 0xF4 clears both parity sets and the byte count, then leaves the block idle. A byte seen while idle, such as the dummy read after a clear, does not change the parity.
- R3: Command 0xB4 starts accumulation. The n-th accepted byte after a clear has index n, counting from 0. Indices 0 to 255 update half A and indices 256 to 511 update half B, at offset index mod 256.
- R4: Let p be the XOR of all 8 bits of a byte at offset a. For each k from 0 to 7, line bit 2k+1 toggles by p when bit k of a is 1, and line bit 2k toggles by p when bit k of a is 0.
- R5: For each j from 0 to 2, column bit 2j+1 accumulates the XOR of the data bits whose bit index has bit j set, and column bit 2j accumulates the others. The column byte is {CP5..CP0, 2'b11}.
- R6: All code bits are presented inverted. An erased all-0xFF chunk therefore reads 0xFFFF in all three words, and so does a half that received no bytes.
- R7: Command 0xD4 enters result mode with the pointer at word 0. Word 0 is {A line[15:8], A line[7:0]}. Word 1 is {B line[7:0], A column byte}. Word 2 is {B column byte, B line[15:8]}. In each word the high byte is listed first.
- R8: In result mode, each `rd_req` advances the pointer, and the read after word 2 returns word 0 again.
- R9: Once 512 bytes have been accepted, further bytes are ignored until the next 0xF4 or reset.
- R10: Any other command code leaves idle mode. It stops accumulation and readout but keeps the parity and the byte count, so a later 0xB4 continues from the same index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A mode command is written this cycle |
| cmd_code | input | 8 | Mode command code |
| byte_valid | input | 1 | A data byte passes the data path this cycle |
| byte_data | input | 8 | The data byte |
| rd_req | input | 1 | Result word read strobe; advances the read pointer |
| rd_word | output | 16 | Current result word in result mode, otherwise zero |

## Verification
The assertions assume that a command write, a data byte and a read strobe never share a cycle. The data path performs one register access at a time. The bench drives exactly one of `cmd_valid`, `byte_valid` and `rd_req` per cycle, separated by idle cycles. When a command does coincide with a byte or a read, the design gives the command priority. The assertions rely on that priority, not on any check of the inputs, to keep the counter and the pointer legal.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int LP_W      = 2 * ADDR_W;
    localparam int BIT_IDX_W = 3;
    localparam int CP_W      = 2 * BIT_IDX_W;
    localparam int WORD_W    = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] CMD_CLEAR  = 8'hF4;
    localparam logic [BYTE_W-1:0] CMD_ACCUM  = 8'hB4;
    localparam logic [BYTE_W-1:0] CMD_RESULT = 8'hD4;

    typedef enum logic [1:0] {
        MODE_IDLE   = 2'd0,
        MODE_ACCUM  = 2'd1,
        MODE_RESULT = 2'd2
    } ecc_mode_e;

    typedef struct packed {
        logic [LP_W-1:0] lp;
        logic [CP_W-1:0] cp;
    } half_code_t;

    // Line-parity contribution of one byte with overall parity p at offset a.
    function automatic logic [LP_W-1:0] line_terms(input logic [ADDR_W-1:0] a,
                                                   input logic p);
        logic [LP_W-1:0] res;
        res = '0;
        for (int k = 0; k < ADDR_W; k++) begin
            res[2*k+1] = p & a[k];
            res[2*k]   = p & ~a[k];
        end
        return res;
    endfunction

    // Column-parity contribution of one byte.
    function automatic logic [CP_W-1:0] col_terms(input logic [BYTE_W-1:0] d);
        logic [CP_W-1:0] res;
        res = '0;
        for (int j = 0; j < BIT_IDX_W; j++) begin
            for (int i = 0; i < BYTE_W; i++) begin
                if (((i >> j) & 1) == 1)
                    res[2*j+1] = res[2*j+1] ^ d[i];
                else
                    res[2*j] = res[2*j] ^ d[i];
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/ecc_cmd_ctrl.sv
module ecc_cmd_ctrl
    import ecc_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_code,
    output ecc_mode_e         mode,
    output logic              clr,
    output logic              start
);

    assign clr   = cmd_valid && (cmd_code == CMD_CLEAR);
    assign start = cmd_valid && (cmd_code == CMD_RESULT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_IDLE;
        end else if (cmd_valid) begin
            case (cmd_code)
                CMD_ACCUM:  mode <= MODE_ACCUM;
                CMD_RESULT: mode <= MODE_RESULT;
                default:    mode <= MODE_IDLE;
            endcase
        end
    end

    // R2: a clear command always lands in idle mode
    assert_clear_idles_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (mode == MODE_IDLE));

endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
    import ecc_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    output half_code_t        code
);

    half_code_t acc;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (en) begin
            acc.lp <= acc.lp ^ line_terms(addr, ^data);
            acc.cp <= acc.cp ^ col_terms(data);
        end
    end

    // Stored inverted so an erased chunk reads as all ones.
    assign code = half_code_t'(~acc);

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (code == '1));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(code));

endmodule

// File: rtl/ecc_result_sel.sv
module ecc_result_sel
    import ecc_gen_pkg::*;
#(
    parameter int NUM_WORDS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic              rd_req,
    input  half_code_t        code_a,
    input  half_code_t        code_b,
    output logic [WORD_W-1:0] rd_word
);

    localparam int PTR_W = $clog2(NUM_WORDS);

    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] col_a, col_b;
    logic [WORD_W-1:0] words [NUM_WORDS];

    assign col_a = {code_a.cp, 2'b11};
    assign col_b = {code_b.cp, 2'b11};

    // Interleaved order: the halves share word 1.
    assign words[0] = {code_a.lp[LP_W-1:BYTE_W], code_a.lp[BYTE_W-1:0]};
    assign words[1] = {code_b.lp[BYTE_W-1:0], col_a};
    assign words[2] = {col_b, code_b.lp[LP_W-1:BYTE_W]};

    always_ff @(posedge clk) begin
        if (rst || start) begin
            ptr <= '0;
        end else if (active && rd_req) begin
            ptr <= (ptr == PTR_W'(NUM_WORDS - 1)) ? '0 : ptr + PTR_W'(1);
        end
    end

    assign rd_word = active ? words[ptr] : '0;

    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (rst)
        ptr < PTR_W'(NUM_WORDS));

    assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (active && rd_req && !start && ptr == PTR_W'(NUM_WORDS - 1)) |=> (ptr == '0));

    assert_start_first_R7: assert property (@(posedge clk) disable iff (rst)
        start |=> (ptr == '0));

endmodule

// File: rtl/dual_hamming_ecc.sv
module dual_hamming_ecc
    import ecc_gen_pkg::*;
#(
    parameter int NUM_HALVES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              rd_req,
    output logic [15:0]       rd_word
);

    localparam int CHUNK_BYTES = NUM_HALVES << ADDR_W;
    localparam int CNT_W       = $clog2(CHUNK_BYTES) + 1;
    localparam int SEL_W       = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;

    ecc_mode_e        mode;
    logic             clr, start, full, accept;
    logic [CNT_W-1:0] cnt;
    half_code_t       codes [NUM_HALVES];

    ecc_cmd_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .mode      (mode),
        .clr       (clr),
        .start     (start)
    );

    assign full   = (cnt == CNT_W'(CHUNK_BYTES));
    assign accept = byte_valid && !cmd_valid && (mode == MODE_ACCUM) && !full;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (accept)
            cnt <= cnt + CNT_W'(1);
    end

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic sel;
        assign sel = (cnt[ADDR_W +: SEL_W] == SEL_W'(h));
        ecc_half_acc u_acc (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .en   (accept && sel),
            .addr (cnt[ADDR_W-1:0]),
            .data (byte_data),
            .code (codes[h])
        );
    end

    ecc_result_sel u_sel (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .active  (mode == MODE_RESULT),
        .rd_req  (rd_req && !cmd_valid),
        .code_a  (codes[0]),
        .code_b  (codes[NUM_HALVES-1]),
        .rd_word (rd_word)
    );

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(CHUNK_BYTES));

    assert_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> $stable(cnt));

    assert_idle_no_count_R2: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_ACCUM && !clr) |=> $stable(cnt));

endmodule

// File: tb/dual_hamming_ecc_bench.sv
`timescale 1ns/1ps
module dual_hamming_ecc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        rd_req = 1'b0;
    logic [15:0] rd_word;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_hamming_ecc u_dual_hamming_ecc (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .rd_req     (rd_req),
        .rd_word    (rd_word)
    );

    // Behavioural reference: 0 idle, 1 accumulate, 2 result
    int          m_mode = 0;
    int          m_cnt  = 0;
    int          m_ptr  = 0;
    logic [15:0] m_lp [2] = '{16'h0, 16'h0};
    logic [5:0]  m_cp [2] = '{6'h0, 6'h0};

    task automatic model_push(input logic [7:0] b);
        int h, a;
        logic p;
        h = m_cnt / 256;
        a = m_cnt % 256;
        p = ^b;
        for (int k = 0; k < 8; k++) begin
            if (((a >> k) & 1) == 1) m_lp[h][2*k+1] ^= p;
            else                     m_lp[h][2*k]   ^= p;
        end
        for (int i = 0; i < 8; i++) begin
            if (b[i]) begin
                for (int j = 0; j < 3; j++)
                    m_cp[h][2*j + ((i >> j) & 1)] ^= 1'b1;
            end
        end
        m_cnt++;
    endtask

    function automatic logic [15:0] model_word();
        logic [15:0] la, lb;
        logic [7:0]  ca, cb;
        la = ~m_lp[0]; lb = ~m_lp[1];
        ca = {~m_cp[0], 2'b11}; cb = {~m_cp[1], 2'b11};
        if (m_mode != 2) return 16'h0000;
        case (m_ptr)
            0:       return la;
            1:       return {lb[7:0], ca};
            default: return {cb, lb[15:8]};
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_ptr = 0;
            m_lp[0] = '0; m_lp[1] = '0; m_cp[0] = '0; m_cp[1] = '0;
        end else if (cmd_valid) begin
            case (cmd_code)
                8'hF4: begin
                    m_mode = 0; m_cnt = 0;
                    m_lp[0] = '0; m_lp[1] = '0; m_cp[0] = '0; m_cp[1] = '0;
                end
                8'hB4: m_mode = 1;
                8'hD4: begin m_mode = 2; m_ptr = 0; end
                default: m_mode = 0;
            endcase
        end else begin
            if (byte_valid && m_mode == 1 && m_cnt < 512) model_push(byte_data);
            if (rd_req && m_mode == 2) m_ptr = (m_ptr + 1) % 3;
        end
    end

    // Per-cycle comparison against the reference (R7, R8, R4, R5)
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rd_word !== model_word()) begin
                failures++;
                $display("FAIL R7 cycle model t=%0t actual=%h expected=%h",
                         $time, rd_word, model_word());
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] exp);
        checks++;
        if (rd_word !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, rd_word, exp);
        end
    endtask

    task automatic cmd(input logic [7:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b);
        byte_valid = 1'b1; byte_data = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [15:0] exp);
        chk(tag, exp);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset word", 16'h0000);

        // Erased chunk with a nonzero dummy read after the clear
        cmd(8'hF4);
        put(8'h5A);
        cmd(8'hB4);
        for (int i = 0; i < 512; i++) put(8'hFF);
        cmd(8'hD4);
        read_chk("R6 erased w0 (R2 dummy ignored)", 16'hFFFF);
        read_chk("R6 erased w1", 16'hFFFF);
        read_chk("R6 erased w2", 16'hFFFF);

        // One set bit: byte 0x01 at A offset 5
        cmd(8'hF4);
        cmd(8'hB4);
        for (int i = 0; i < 5; i++) put(8'h00);
        put(8'h01);
        cmd(8'hD4);
        read_chk("R4 line A w0", 16'hAA99);
        read_chk("R5 column A w1", 16'hFFAB);
        read_chk("R7 word2 untouched B", 16'hFFFF);
        read_chk("R8 wrap to w0", 16'hAA99);

        // Byte 0x80 at B offset 3
        cmd(8'hF4);
        cmd(8'hB4);
        for (int i = 0; i < 259; i++) put(8'h00);
        put(8'h80);
        cmd(8'hD4);
        read_chk("R3 half A idle w0", 16'hFFFF);
        read_chk("R3 half B low w1", 16'hA5FF);
        read_chk("R3 half B high w2", 16'h57AA);

        // Bytes past 512 ignored
        cmd(8'hF4);
        cmd(8'hB4);
        for (int i = 0; i < 512; i++) put(8'h00);
        put(8'h01);
        put(8'h80);
        cmd(8'hD4);
        read_chk("R9 overflow w0", 16'hFFFF);
        read_chk("R9 overflow w1", 16'hFFFF);
        read_chk("R9 overflow w2", 16'hFFFF);

        // Other command pauses accumulation and keeps the count
        cmd(8'hF4);
        cmd(8'hB4);
        for (int i = 0; i < 3; i++) put(8'h00);
        cmd(8'h94);
        chk("R10 other mode reads zero", 16'h0000);
        put(8'h01);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        cmd(8'hB4);
        put(8'h00); put(8'h00); put(8'h01);
        cmd(8'hD4);
        read_chk("R10 resumed index w0", 16'hAA99);
        read_chk("R10 resumed index w1", 16'hFFAB);

        // Pseudo-random full chunk, checked by the reference model
        cmd(8'hF4);
        cmd(8'hB4);
        s = 8'hA5;
        for (int i = 0; i < 512; i++) begin
            put(s);
            s = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
        end
        cmd(8'hD4);
        for (int i = 0; i < 4; i++) read_chk("R4 R5 random chunk", model_word());

        // Reset in the middle of accumulation
        cmd(8'hF4);
        cmd(8'hB4);
        for (int i = 0; i < 7; i++) put(8'h3C);
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        chk("R1 reset leaves result mode", 16'h0000);
        cmd(8'hD4);
        read_chk("R1 reset cleared w0", 16'hFFFF);
        read_chk("R1 reset cleared w1", 16'hFFFF);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule